// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block decides when a plug-in card's two-wire bus (clock and data) may be joined to a bus on a live backplane. It watches a synchronous enable, an undervoltage flag and the sampled levels of the four bus lines. From these it drives a connect strobe for the pass switches, a precharge enable for the card-side inputs, and an active-high READY flag.

After enable, and only while supply is good, the controller runs a fixed initialization delay with precharge on. After that it arms its bus watchers. It connects the two sides once all four lines have stayed high for an unbroken idle window. It also connects when a STOP appears on the backplane pair (data rising while clock is high) with all four lines high. Once connected, it stays connected until enable drops or undervoltage is flagged. Bus traffic has no effect on the connection. Both intervals are parameters counted in clock cycles.

Top module: `hs_link_ctrl`

## Requirements
- R1: After reset, `link_on`, `prechg_on` and `ready` are all 0.
- R2: While `uv_fault` is 1, the block is disconnected with all outputs 0. Raising `uv_fault` while connected clears all outputs after the next clock edge.
- R3: `en` at 0 clears `link_on`, `ready` and `prechg_on` after the next clock edge, whatever the current phase.
- R4: When `en`=1 and `uv_fault`=0 are first seen together at a clock edge (enable rising, or supply becoming good), initialization starts. It lasts `INIT_CYCLES` edges, with `prechg_on`=1 and `ready`=0.
- R5: With all four lines high throughout, `ready` rises exactly `INIT_CYCLES+IDLE_CYCLES` edges after the edge that started initialization.
- R6: After initialization, a rising edge of backplane data while backplane clock is high, with all four lines high, connects the block. This happens on the third clock edge after the input change: two synchronizer stages plus the state register.
- R7: A STOP that occurs during initialization does not connect early. Connection then follows the idle rule of R5.
- R8: Any of the four lines going low during the idle wait restarts the idle count from zero. A one-cycle low on a card line delays `ready` to `IDLE_CYCLES+3` edges after the edge where the low was first applied.
- R9: `prechg_on` is 1 from the start of initialization up to the connecting edge, and 0 while connected.
- R10: Once connected, toggling any bus line never drops `link_on` or `ready`.
- R11: `ready` equals `link_on` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable, active high |
| uv_fault | input | 1 | Undervoltage flag, active high |
| bp_scl | input | 1 | Sampled backplane clock line |
| bp_sda | input | 1 | Sampled backplane data line |
| cd_scl | input | 1 | Sampled card clock line |
| cd_sda | input | 1 | Sampled card data line |
| link_on | output | 1 | Connect strobe for the pass switches |
| prechg_on | output | 1 | Precharge enable |
| ready | output | 1 | Sides connected flag, active high |

## Verification
The hardest situation to reach is a STOP connection that wins over the idle timer. It needs the controller past initialization while the idle count cannot complete. The stimulus gets there by holding backplane data low through enable and initialization. This blocks the idle window, so the later rising data edge alone decides the connect cycle. The idle-restart case uses a similar approach: it drops a card line for one cycle partway through the wait and measures the edge count to `ready` from that disturbance.

// File: rtl/hs_link_ctrl.sv
module hs_link_ctrl #(
  parameter int INIT_CYCLES = 13750,
  parameter int IDLE_CYCLES = 13125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic uv_fault,
  input  logic bp_scl,
  input  logic bp_sda,
  input  logic cd_scl,
  input  logic cd_sda,
  output logic link_on,
  output logic prechg_on,
  output logic ready
);
  localparam int MAXC = (INIT_CYCLES > IDLE_CYCLES) ? INIT_CYCLES : IDLE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_OFF, S_INIT, S_WAIT, S_LINK} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0] sy1, sy2;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
      sda_prev <= 1'b1;
    end else begin
      sy1 <= {bp_scl, bp_sda, cd_scl, cd_sda};
      sy2 <= sy1;
      sda_prev <= sy2[2];
    end
  end

  wire go     = en & ~uv_fault;
  wire all_hi = &sy2;
  wire stop_s = sy2[3] & sy2[2] & ~sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else if (!go) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      unique case (st)
        S_OFF: begin
          st  <= S_INIT;
          cnt <= '0;
        end
        S_INIT:
          if (cnt == CW'(INIT_CYCLES - 1)) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_WAIT:
          if (!all_hi) cnt <= '0;
          else if (stop_s || cnt == CW'(IDLE_CYCLES - 1)) begin
            st  <= S_LINK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        default: st <= S_LINK;
      endcase
    end
  end

  assign link_on   = (st == S_LINK);
  assign ready     = link_on;
  assign prechg_on = (st == S_INIT) || (st == S_WAIT);
endmodule

// File: rtl/hs_link_ctrl_chk.sv
module hs_link_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic uv_fault,
  input logic link_on,
  input logic prechg_on,
  input logic ready
);
  a_r2_uv_drop: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> !link_on && !prechg_on);
  a_r3_en_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready && !prechg_on && !link_on);
  a_r9_prechg_before_link: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_on) |-> $past(prechg_on));
  a_r10_hold_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_on && en && !uv_fault |=> link_on);
  a_r4_init_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prechg_on) |-> !ready);
  a_r11_ready_link: assert property (@(posedge clk) disable iff (!rst_n)
    ready == link_on);
endmodule

bind hs_link_ctrl hs_link_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .uv_fault(uv_fault),
  .link_on(link_on), .prechg_on(prechg_on), .ready(ready)
);

// File: tb/tb_hs_link_ctrl.sv
module tb_hs_link_ctrl;
  localparam int INIT = 20;
  localparam int IDLE = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, uv_fault = 1'b0;
  logic bp_scl = 1'b1, bp_sda = 1'b1, cd_scl = 1'b1, cd_sda = 1'b1;
  logic link_on, prechg_on, ready;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hs_link_ctrl #(.INIT_CYCLES(INIT), .IDLE_CYCLES(IDLE)) dut (.*);

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_ready(int start, output int n);
    n = start;
    while (!ready && n < 2000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic go_off();
    @(negedge clk);
    en = 1'b0; uv_fault = 1'b0;
    bp_scl = 1'b1; bp_sda = 1'b1; cd_scl = 1'b1; cd_sda = 1'b1;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 link", link_on, 0);
    check("R1 prechg", prechg_on, 0);
    check("R1 ready", ready, 0);
  endtask

  task automatic t_idle_connect();
    int n;
    @(negedge clk) en = 1'b1;
    @(posedge clk); #1;
    check("R4 prechg in init", prechg_on, 1);
    check("R4 ready in init", ready, 0);
    count_ready(1, n);
    check("R5 idle connect edges", n, INIT + IDLE + 1);
    check("R9 prechg off when linked", prechg_on, 0);
    check("R11 ready==link", ready, link_on);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      bp_scl = i[0]; bp_sda = i[1]; cd_scl = i[2]; cd_sda = ~i[0];
    end
    @(posedge clk); #1;
    check("R10 link kept under traffic", link_on, 1);
    check("R10 ready kept", ready, 1);
    @(negedge clk) en = 1'b0;
    @(posedge clk); #1;
    check("R3 en low ready", ready, 0);
    check("R3 en low link", link_on, 0);
    check("R3 en low prechg", prechg_on, 0);
    go_off();
  endtask

  task automatic t_stop_connect();
    int n;
    @(negedge clk) begin bp_sda = 1'b0; en = 1'b1; end
    repeat (INIT + 5) @(posedge clk);
    #1;
    check("R9 prechg in wait", prechg_on, 1);
    check("R6 not yet linked", link_on, 0);
    @(negedge clk) bp_sda = 1'b1;
    count_ready(0, n);
    check("R6 stop connect edges", n, 3);
    check("R9 prechg after stop link", prechg_on, 0);
    go_off();
  endtask

  task automatic t_stop_in_init();
    int n;
    @(negedge clk) begin bp_sda = 1'b0; en = 1'b1; end
    repeat (3) @(posedge clk);
    @(negedge clk) bp_sda = 1'b1;
    count_ready(3, n);
    check("R7 stop in init ignored", n, INIT + IDLE + 1);
    go_off();
  endtask

  task automatic t_idle_restart();
    int n;
    @(negedge clk) en = 1'b1;
    repeat (INIT + 10) @(posedge clk);
    @(negedge clk) cd_scl = 1'b0;
    @(negedge clk) cd_scl = 1'b1;
    #1;
    check("R8 not linked after glitch", ready, 0);
    count_ready(1, n);
    check("R8 idle restart edges", n, IDLE + 3);
    go_off();
  endtask

  task automatic t_power_good();
    int n;
    @(negedge clk) begin uv_fault = 1'b1; en = 1'b1; end
    repeat (INIT + IDLE + 10) @(posedge clk);
    #1;
    check("R2 uv held off link", link_on, 0);
    check("R2 uv held off prechg", prechg_on, 0);
    @(negedge clk) uv_fault = 1'b0;
    count_ready(0, n);
    check("R4 power good start edges", n, INIT + IDLE + 1);
    @(negedge clk) uv_fault = 1'b1;
    @(posedge clk); #1;
    check("R2 uv drops link", link_on, 0);
    check("R2 uv drops ready", ready, 0);
    go_off();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_idle_connect();
    t_stop_connect();
    t_stop_in_init();
    t_idle_restart();
    t_power_good();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule